// File: doc/BRIEF.md
# Serial DAC Write Sequencer

This block sits on the host side of a serial-input current-output DAC. It takes a 12-bit sample from a valid/ready request port and plays it out over three wires: a shift clock, a serial data line and an active-low load strobe. The bits go out most significant first. Data changes only on falling shift-clock edges, and the DAC samples it on rising edges. Once the last bit has been shifted in and a post-bit delay has passed, the block pulses the load strobe low. That pulse moves the DAC's shift register into its transparent-while-low output register.

The clock high and low phases, the post-bit delay and the strobe width are all counted in system-clock cycles and set by parameters. Each count should be rounded up so that the nanosecond minimums hold at the chosen clock. With the defaults at 4 ns per cycle the phases are 92 ns high and 120 ns low, and the strobe is 120 ns wide. The setup time of 40 ns is covered by the low phase and the hold time of 80 ns by the high phase. A mode input sampled with the request inverts the MSB, which turns a two's-complement code into offset binary.

Top module: `dac_wr_seq`

## Requirements
- R1: While reset is asserted, and whenever the block is idle, `sclk_o`, `sdi_o` and `ld_n_o` are all 1 and `ready_o` is 1.
- R2: A request is taken only on a clock edge where `valid_i` and `ready_o` are both 1. `ready_o` falls in the next cycle, and `valid_i` has no effect while `ready_o` is 0.
- R3: One transfer shifts exactly 12 bits, bit 11 first and bit 0 last. `sdi_o` changes only in the same cycle as a falling `sclk_o` while a transfer is running.
- R4: Every low phase of `sclk_o` lasts `LO_CYC` cycles and every high phase between bits lasts `HI_CYC` cycles. A transfer produces 12 rising edges.
- R5: `ld_n_o` stays 1 through the whole shift, and `sclk_o` is held at 1 for as long as `ld_n_o` is 0.
- R6: `ld_n_o` falls `HI_CYC + LD_DLY_CYC` cycles after the rising edge that shifts bit 0, and stays 0 for `LD_CYC` cycles.
- R7: When `tc_mode_i` is 1 at acceptance, bit 11 of the word is inverted before shifting. When it is 0, the word is shifted unchanged.
- R8: `ready_o` returns to 1 in the cycle after the strobe ends, with all three lines high. A transfer therefore keeps `ready_o` low for 12·(`LO_CYC`+`HI_CYC`)+`LD_DLY_CYC`+`LD_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample request |
| data_i | input | 12 | Sample word |
| tc_mode_i | input | 1 | 1: treat the word as two's complement (invert bit 11) |
| ready_o | output | 1 | Idle and able to take a request |
| sclk_o | output | 1 | DAC shift clock |
| sdi_o | output | 1 | DAC serial data |
| ld_n_o | output | 1 | DAC load strobe, active low |

## Verification
All-zero and all-one words show whether every bit slot is driven from the word at all. Alternating patterns such as 0xA5A and 0x5A5 expose swapped or shifted bit order. The two's-complement codes 0x800, 0x7FF and 0x001 separate a correct MSB inversion from an inversion of the wrong bit or none. Back-to-back requests and a request held high in the middle of a transfer test that acceptance depends only on the idle state. The reference model predicts every output in every cycle, so phase lengths and strobe placement are checked at cycle accuracy.

// File: rtl/dac_wr_pkg.sv
package dac_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LO,
    ST_HI,
    ST_WAIT,
    ST_LOAD
  } seq_st_e;
endpackage

// File: rtl/dac_phase_timer.sv
module dac_phase_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/dac_word_shreg.sv
module dac_word_shreg #(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  output logic              msb_o
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= '1;
    else if (load_i)   sh_q <= data_i;
    else if (shift_i)  sh_q <= {sh_q[DATA_W-2:0], 1'b1};
  end

  assign msb_o = sh_q[DATA_W-1];
endmodule

// File: rtl/dac_wr_seq.sv
module dac_wr_seq
  import dac_wr_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int HI_CYC     = 23,
  parameter int LO_CYC     = 30,
  parameter int LD_DLY_CYC = 1,
  parameter int LD_CYC     = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              tc_mode_i,
  output logic              ready_o,
  output logic              sclk_o,
  output logic              sdi_o,
  output logic              ld_n_o
);
  localparam int M_PH  = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
  localparam int M_LD  = (LD_CYC > LD_DLY_CYC) ? LD_CYC : LD_DLY_CYC;
  localparam int M_ALL = (M_PH > M_LD) ? M_PH : M_LD;
  localparam int CNT_W = $clog2(M_ALL + 1);
  localparam int BIT_W = $clog2(DATA_W);

  seq_st_e          st_q, st_d;
  logic [BIT_W-1:0] bit_q;
  logic             tmr_done, tmr_load, sh_load, sh_shift, sh_msb;
  logic [CNT_W-1:0] tmr_val;
  logic [DATA_W-1:0] word;

  // two's complement -> offset binary by flipping the sign bit
  assign word = data_i ^ {tc_mode_i, {(DATA_W-1){1'b0}}};

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (st_q)
      ST_IDLE: if (valid_i) begin
        st_d = ST_LO; tmr_load = 1'b1; tmr_val = CNT_W'(LO_CYC - 1); sh_load = 1'b1;
      end
      ST_LO: if (tmr_done) begin
        st_d = ST_HI; tmr_load = 1'b1; tmr_val = CNT_W'(HI_CYC - 1);
      end
      ST_HI: if (tmr_done) begin
        tmr_load = 1'b1;
        if (bit_q == BIT_W'(DATA_W - 1)) begin
          st_d = ST_WAIT; tmr_val = CNT_W'(LD_DLY_CYC - 1);
        end else begin
          st_d = ST_LO; tmr_val = CNT_W'(LO_CYC - 1); sh_shift = 1'b1;
        end
      end
      ST_WAIT: if (tmr_done) begin
        st_d = ST_LOAD; tmr_load = 1'b1; tmr_val = CNT_W'(LD_CYC - 1);
      end
      ST_LOAD: if (tmr_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      bit_q <= '0;
    end else begin
      st_q <= st_d;
      if (sh_load)       bit_q <= '0;
      else if (sh_shift) bit_q <= bit_q + BIT_W'(1);
    end
  end

  dac_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  dac_word_shreg #(.DATA_W(DATA_W)) u_shreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (sh_load),
    .data_i  (word),
    .shift_i (sh_shift),
    .msb_o   (sh_msb)
  );

  assign ready_o = (st_q == ST_IDLE);
  assign sclk_o  = (st_q != ST_LO);
  assign ld_n_o  = (st_q != ST_LOAD);
  assign sdi_o   = (st_q == ST_IDLE) ? 1'b1 : sh_msb;
endmodule

// File: rtl/dac_wr_seq_chk.sv
module dac_wr_seq_chk #(
  parameter int HI_CYC     = 23,
  parameter int LO_CYC     = 30,
  parameter int LD_DLY_CYC = 1,
  parameter int LD_CYC     = 30
) (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic ready_o,
  input logic sclk_o,
  input logic sdi_o,
  input logic ld_n_o
);
  int lo_run, hi_run, ld_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_run <= 0; hi_run <= 0; ld_run <= 0;
    end else begin
      lo_run <= sclk_o ? 0 : lo_run + 1;
      hi_run <= sclk_o ? hi_run + 1 : 0;
      ld_run <= ld_n_o ? 0 : ld_run + 1;
    end
  end

  // R1
  idle_lines_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (sclk_o && sdi_o && ld_n_o));

  // R2
  accept_drops_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !ready_o);

  // R3
  sdi_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sdi_o) && !ready_o) |-> $fell(sclk_o));

  // R4
  lo_phase_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> (lo_run == LO_CYC));

  // R4
  hi_phase_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sclk_o) && !$past(ready_o)) |-> (hi_run == HI_CYC));

  // R5
  no_clk_in_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_n_o |-> sclk_o);

  // R6
  load_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ld_n_o) |-> (hi_run == HI_CYC + LD_DLY_CYC));

  // R6
  load_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ld_n_o) |-> (ld_run == LD_CYC));

  // R8
  ready_after_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ld_n_o) |-> ready_o);
endmodule

bind dac_wr_seq dac_wr_seq_chk #(
  .HI_CYC(HI_CYC), .LO_CYC(LO_CYC), .LD_DLY_CYC(LD_DLY_CYC), .LD_CYC(LD_CYC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .ready_o(ready_o),
  .sclk_o(sclk_o), .sdi_o(sdi_o), .ld_n_o(ld_n_o)
);

// File: tb/dac_wr_seq_bench.sv
module dac_wr_seq_bench;
  localparam int DW  = 12;
  localparam int HI  = 23;
  localparam int LO  = 30;
  localparam int DLY = 1;
  localparam int LD  = 30;
  localparam int P   = LO + HI;
  localparam int SH  = DW * P;
  localparam int TOT = SH + DLY + LD;

  logic clk = 1'b0, rst_n = 1'b0, valid = 1'b0, tc = 1'b0;
  logic [DW-1:0] data = '0;
  logic ready, sclk, sdi, ld_n;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dac_wr_seq u_dac_wr_seq (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .data_i(data), .tc_mode_i(tc),
    .ready_o(ready), .sclk_o(sclk), .sdi_o(sdi), .ld_n_o(ld_n)
  );

  // reference model
  bit m_busy = 0, m_tc = 0;
  int m_t = 0;
  logic [DW-1:0] m_word = '0;

  always @(posedge clk) begin
    if (!rst_n) m_busy = 0;
    else if (!m_busy) begin
      if (valid) begin
        m_busy = 1; m_t = 0; m_tc = tc;
        m_word = data ^ (tc ? 12'h800 : 12'h000);
      end
    end else if (m_t == TOT - 1) m_busy = 0;
    else m_t++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      logic e_sclk, e_sdi, e_ld, e_rdy;
      int b;
      b = 0;
      if (!m_busy) begin
        e_sclk = 1; e_sdi = 1; e_ld = 1; e_rdy = 1;
      end else begin
        e_rdy = 0;
        if (m_t < SH) begin
          b = m_t / P;
          e_sclk = (m_t % P) >= LO;
          e_sdi = m_word[DW-1-b];
          e_ld = 1;
        end else begin
          b = DW - 1;
          e_sclk = 1; e_sdi = m_word[0];
          e_ld = (m_t < SH + DLY);
        end
      end
      check(sclk == e_sclk, e_ld ? "R4" : "R5", sclk, e_sclk);
      check(sdi == e_sdi, (m_busy && m_tc && b == 0) ? "R7" : "R3", sdi, e_sdi);
      check(ld_n == e_ld, "R6", ld_n, e_ld);
      check(ready == e_rdy, "R8", ready, e_rdy);
    end
  end

  task automatic send(input logic [DW-1:0] w, input logic m);
    do @(negedge clk); while (!ready);
    valid = 1'b1; data = w; tc = m;
    @(negedge clk);
    valid = 1'b0; data = ~w; tc = ~m;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: lines high during reset
    check(sclk && sdi && ld_n && ready, "R1", {sclk, sdi, ld_n, ready}, 4'hF);
    rst_n = 1'b1;
    @(negedge clk);
    check(sclk && sdi && ld_n && ready, "R1", {sclk, sdi, ld_n, ready}, 4'hF);

    send(12'h000, 1'b0);
    send(12'hFFF, 1'b0);
    send(12'hA5A, 1'b0);
    // R2: request held mid-transfer must be ignored
    repeat (100) @(negedge clk);
    valid = 1'b1; data = 12'h3C3; tc = 1'b1;
    repeat (50) begin
      @(negedge clk);
      check(!ready, "R2", ready, 0);
    end
    valid = 1'b0;
    send(12'h5A5, 1'b0);
    // R7: two's complement codes
    send(12'h800, 1'b1);
    send(12'h7FF, 1'b1);
    send(12'h001, 1'b1);
    send(12'h123, 1'b0);
    do @(negedge clk); while (!ready);
    repeat (5) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end
endmodule